// File: doc/BRIEF.md
# Hashed Sparse Voxel Lookup Unit

This unit returns the stored feature value and density for one integer voxel vertex of a sparse, compressed voxel grid. It is meant for a rendering pipeline that handles one vertex per cycle. Only the non-empty vertices of the grid have data. They are reached through a spatial hash rather than through stored coordinates. The grid is cut along the x axis into equal slabs, and each slab owns a separate hash table. A table entry holds a lookup index and a density.

The lookup index lives in one flat address space. Low index values select a small codebook of shared feature values. Higher values select a larger memory of raw quantised features. The output carries a flag that tells later stages which of the two it came from, so they can dequantise correctly.

Two vertices can hash onto the same slot, and the table then returns the wrong data for one of them. To hide this, a one-bit-per-vertex occupancy bitmap is read in parallel with the table, and any vertex marked empty yields zero feature and zero density. All memories are preloaded through a plain synchronous write port. The lookup path is a three-stage pipeline with a valid/ready handshake on both sides.

Top module: `vox_sparse_lookup`

## Requirements
- R1: The slab (hash table bank) of a vertex is x divided by the slab width GRID_X/NUM_SUB, which equals the top log2(NUM_SUB) bits of x. With the defaults (4-bit coordinates, 4 slabs) the slab number is x/4.
- R2: The slot inside a bank is the low TBL_BITS bits of (x*1) XOR (y*2654435761) XOR (z*805459861), with each product taken modulo 2^32. There are 64 slots by default.
- R3: A table entry is written with wr_sel=0 at wr_addr = {slab, slot}, with the slab in the upper bits. wr_data[IDX_W-1:0] is the lookup index, and wr_data[IDX_W+DENS_W-1:IDX_W] is the density.
- R4: For an occupied vertex whose index is below CB_DEPTH (256 by default), out_feat is codebook word [index] and out_raw is 0.
- R5: For an occupied vertex whose index is CB_DEPTH or more, out_feat is raw word [(index - CB_DEPTH) mod RAW_DEPTH] and out_raw is 1.
- R6: The occupancy bit of vertex (x,y,z) sits at linear position (x*GY + y)*GZ + z, which is {x,y,z} concatenated. Its word address is that position divided by 32 and its bit select is the position mod 32. When the bit is 0, out_feat and out_dens are 0, whatever the table holds. out_raw still reports the routing implied by the index.
- R7: For an occupied vertex, out_dens equals the density field of the table entry it hashes to.
- R8: A request accepted at a rising edge appears on the output three cycles later when no stall occurs. One request can be accepted in every cycle.
- R9: While out_valid is 1 and out_ready is 0, in_ready is 0 and out_valid, out_feat, out_dens and out_raw hold their values. Requests are neither lost nor reordered.
- R10: After a clock edge with rst_n low, out_valid is 0 and in_ready is 1.
- R11: The write port selects its target with wr_sel: 0 hash table, 1 codebook (wr_addr = word, data in wr_data[FEAT_W-1:0]), 2 raw memory (same layout), 3 occupancy bitmap (wr_addr = word address, data in wr_data[31:0]).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Lookup request present |
| in_ready | output | 1 | Request accepted this cycle |
| in_x | input | CW | Vertex x coordinate (slab axis) |
| in_y | input | CW | Vertex y coordinate |
| in_z | input | CW | Vertex z coordinate |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Downstream takes the result |
| out_feat | output | FEAT_W | Feature word, zero when empty |
| out_dens | output | DENS_W | Density, zero when empty |
| out_raw | output | 1 | 1 = raw quantised memory, 0 = codebook |
| wr_en | input | 1 | Preload write strobe |
| wr_sel | input | 2 | Preload target select |
| wr_addr | input | WR_AW | Preload word address |
| wr_data | input | WR_DW | Preload data |

## Verification
A wrong slab or slot choice shows up as a feature or density taken from some other vertex on the first lookup that reaches the affected entry. A wrong bitmap address shows up as a non-zero result for an empty vertex that collides with an occupied one, or as a zero result for a real vertex, again on the very next affected result. Valid bits that are lost or duplicated in a stage show up within three cycles as out_valid disagreeing with the reference pipeline. Under backpressure they show up as a result that changes while it is being held.

// File: rtl/vox_pkg.sv
// Shared definitions for the sparse voxel lookup unit.
// Assumes: none; pure constants and types.
package vox_pkg;
    // Targets of the preload write port.
    typedef enum logic [1:0] {
        WS_TABLE    = 2'd0,
        WS_CODEBOOK = 2'd1,
        WS_RAW      = 2'd2,
        WS_BITMAP   = 2'd3
    } wsel_e;

    // Hash multipliers applied to y and z (x uses 1).
    localparam logic [31:0] HASH_MY = 32'd2654435761;
    localparam logic [31:0] HASH_MZ = 32'd805459861;
endpackage

// File: rtl/vox_addr_gen.sv
// Address generation: slab number, hash slot and occupancy bit address.
// Purely combinational.
// Assumes: the slab count is a power of two, so the slab number is the top bits of x.
// Assumes: the bitmap word is narrower than the grid, i.e. 3*CW > WSEL_BITS.
module vox_addr_gen
    import vox_pkg::*;
#(
    parameter int CW        = 4,
    parameter int SUB_BITS  = 2,
    parameter int TBL_BITS  = 6,
    parameter int WSEL_BITS = 5,
    localparam int BM_AW    = 3 * CW - WSEL_BITS
) (
    input  logic [CW-1:0]        x_i,
    input  logic [CW-1:0]        y_i,
    input  logic [CW-1:0]        z_i,
    output logic [SUB_BITS-1:0]  sub_o,
    output logic [TBL_BITS-1:0]  slot_o,
    output logic [BM_AW-1:0]     bm_word_o,
    output logic [WSEL_BITS-1:0] bm_bit_o
);
    logic [3*CW-1:0] lin;

    // Slab select and spatial hash, truncated to the table size.
    always_comb begin
        sub_o  = x_i[CW-1 -: SUB_BITS];
        slot_o = TBL_BITS'(32'(x_i))
               ^ TBL_BITS'(32'(y_i) * HASH_MY)
               ^ TBL_BITS'(32'(z_i) * HASH_MZ);
    end

    // Linear vertex position, split into word address and bit select.
    always_comb begin
        lin       = {x_i, y_i, z_i};
        bm_word_o = lin[3*CW-1:WSEL_BITS];
        bm_bit_o  = lin[WSEL_BITS-1:0];
    end
endmodule

// File: rtl/vox_hash_tables.sv
// Bank of per-slab hash tables. Each entry packs {density, index}.
// Every bank reads the slot in parallel on an advancing cycle, and the
// registered slab number picks one bank's result in the following cycle.
// Assumes: the memories are not reset; software preloads them.
module vox_hash_tables #(
    parameter int NUM_SUB  = 4,
    parameter int SUB_BITS = 2,
    parameter int TBL_BITS = 6,
    parameter int ENT_W    = 34,
    localparam int DEPTH   = 1 << TBL_BITS
) (
    input  logic                         clk,
    input  logic                         adv,
    input  logic [SUB_BITS-1:0]          rd_sub,
    input  logic [TBL_BITS-1:0]          rd_slot,
    input  logic                         we,
    input  logic [SUB_BITS+TBL_BITS-1:0] wr_addr,
    input  logic [ENT_W-1:0]             wr_data,
    output logic [ENT_W-1:0]             entry_o
);
    logic [SUB_BITS-1:0] sub_q;
    logic [ENT_W-1:0]    bank_rd [NUM_SUB];

    // Remember which bank the current read belongs to.
    always_ff @(posedge clk) begin
        if (adv) sub_q <= rd_sub;
    end

    for (genvar b = 0; b < NUM_SUB; b++) begin : g_bank
        logic [ENT_W-1:0] mem [DEPTH];
        logic [ENT_W-1:0] rd_q;

        // Preload write into this bank, and registered read of the slot.
        always_ff @(posedge clk) begin
            if (we && wr_addr[TBL_BITS +: SUB_BITS] == SUB_BITS'(b))
                mem[wr_addr[TBL_BITS-1:0]] <= wr_data;
            if (adv) rd_q <= mem[rd_slot];
        end

        assign bank_rd[b] = rd_q;
    end

    assign entry_o = bank_rd[sub_q];
endmodule

// File: rtl/vox_bitmap.sv
// Occupancy bitmap: one bit per grid vertex, stored in 2**WSEL_BITS-bit words.
// Reads the word and the bit select in one stage, then exposes the selected bit.
// Assumes: the bitmap is preloaded before lookups start.
module vox_bitmap #(
    parameter int BM_AW     = 7,
    parameter int WSEL_BITS = 5,
    localparam int WORD_W   = 1 << WSEL_BITS,
    localparam int WORDS    = 1 << BM_AW
) (
    input  logic                 clk,
    input  logic                 adv,
    input  logic [BM_AW-1:0]     rd_word,
    input  logic [WSEL_BITS-1:0] rd_bit,
    input  logic                 we,
    input  logic [BM_AW-1:0]     wr_addr,
    input  logic [WORD_W-1:0]    wr_data,
    output logic                 occ_o
);
    logic [WORD_W-1:0]    mem [WORDS];
    logic [WORD_W-1:0]    word_q;
    logic [WSEL_BITS-1:0] bit_q;

    // Preload write, and registered word read with its bit select.
    always_ff @(posedge clk) begin
        if (we) mem[wr_addr] <= wr_data;
        if (adv) begin
            word_q <= mem[rd_word];
            bit_q  <= rd_bit;
        end
    end

    assign occ_o = word_q[bit_q];
endmodule

// File: rtl/vox_feature_route.sv
// Final stage: routes the lookup index either to the codebook or to the raw
// memory, applies the occupancy mask, and owns the output registers.
// Assumes: a raw index wraps modulo RAW_DEPTH; both depths are powers of two.
module vox_feature_route #(
    parameter int IDX_W     = 18,
    parameter int DENS_W    = 16,
    parameter int FEAT_W    = 16,
    parameter int CB_DEPTH  = 256,
    parameter int RAW_DEPTH = 256,
    localparam int CB_AW    = $clog2(CB_DEPTH),
    localparam int RAW_AW   = $clog2(RAW_DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              adv,
    input  logic              valid_i,
    input  logic [IDX_W-1:0]  idx_i,
    input  logic [DENS_W-1:0] dens_i,
    input  logic              occ_i,
    input  logic              we_cb,
    input  logic              we_raw,
    input  logic [CB_AW-1:0]  wa_cb,
    input  logic [RAW_AW-1:0] wa_raw,
    input  logic [FEAT_W-1:0] wd,
    output logic              valid_o,
    output logic [FEAT_W-1:0] feat_o,
    output logic [DENS_W-1:0] dens_o,
    output logic              raw_o
);
    logic [FEAT_W-1:0] cb_mem  [CB_DEPTH];
    logic [FEAT_W-1:0] raw_mem [RAW_DEPTH];
    logic              is_cb;
    logic [RAW_AW-1:0] raw_addr;
    logic [FEAT_W-1:0] pick;

    // Preload writes for both feature memories.
    always_ff @(posedge clk) begin
        if (we_cb)  cb_mem[wa_cb]   <= wd;
        if (we_raw) raw_mem[wa_raw] <= wd;
    end

    // Threshold split of the shared index space.
    always_comb begin
        is_cb    = idx_i < IDX_W'(CB_DEPTH);
        raw_addr = RAW_AW'(idx_i - IDX_W'(CB_DEPTH));
        pick     = is_cb ? cb_mem[idx_i[CB_AW-1:0]] : raw_mem[raw_addr];
    end

    // Output valid flag, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n)   valid_o <= 1'b0;
        else if (adv) valid_o <= valid_i;
    end

    // Output data with the occupancy mask applied.
    always_ff @(posedge clk) begin
        if (adv) begin
            feat_o <= occ_i ? pick   : '0;
            dens_o <= occ_i ? dens_i : '0;
            raw_o  <= !is_cb;
        end
    end

    AST_EMPTY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        valid_i && adv && !occ_i |=> feat_o == '0 && dens_o == '0); // R6
    AST_CB_ROUTE: assert property (@(posedge clk) disable iff (!rst_n)
        valid_i && adv && idx_i < IDX_W'(CB_DEPTH) |=> !raw_o); // R4
    AST_RAW_ROUTE: assert property (@(posedge clk) disable iff (!rst_n)
        valid_i && adv && idx_i >= IDX_W'(CB_DEPTH) |=> raw_o); // R5
    AST_OCC_DENS: assert property (@(posedge clk) disable iff (!rst_n)
        valid_i && adv && occ_i |=> dens_o == $past(dens_i)); // R7
    AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o && !adv |=> valid_o && $stable(feat_o) && $stable(dens_o) && $stable(raw_o)); // R9
endmodule

// File: rtl/vox_sparse_lookup.sv
// Top of the hashed sparse voxel lookup unit. It is a three-stage pipeline:
//   S1 registers the slab, slot and bitmap address of the request;
//   S2 reads the hash table banks and the bitmap word;
//   S3 routes the index to a feature memory and masks empty vertices.
// One global advance signal freezes every stage while the output is held.
// Assumes: preload writes are not mixed with lookups of the entries they change.
module vox_sparse_lookup
    import vox_pkg::*;
#(
    parameter int CW        = 4,
    parameter int NUM_SUB   = 4,
    parameter int TBL_BITS  = 6,
    parameter int WSEL_BITS = 5,
    parameter int IDX_W     = 18,
    parameter int DENS_W    = 16,
    parameter int FEAT_W    = 16,
    parameter int CB_DEPTH  = 256,
    parameter int RAW_DEPTH = 256,
    parameter int WR_AW     = 8,
    parameter int WR_DW     = IDX_W + DENS_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [CW-1:0]     in_x,
    input  logic [CW-1:0]     in_y,
    input  logic [CW-1:0]     in_z,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [FEAT_W-1:0] out_feat,
    output logic [DENS_W-1:0] out_dens,
    output logic              out_raw,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [WR_AW-1:0]  wr_addr,
    input  logic [WR_DW-1:0]  wr_data
);
    localparam int SUB_BITS = $clog2(NUM_SUB);
    localparam int ENT_W    = IDX_W + DENS_W;
    localparam int TADDR_W  = SUB_BITS + TBL_BITS;
    localparam int BM_AW    = 3 * CW - WSEL_BITS;
    localparam int WORD_W   = 1 << WSEL_BITS;
    localparam int CB_AW    = $clog2(CB_DEPTH);
    localparam int RAW_AW   = $clog2(RAW_DEPTH);

    wsel_e                wsel;
    logic                 adv;
    logic [SUB_BITS-1:0]  g_sub;
    logic [TBL_BITS-1:0]  g_slot;
    logic [BM_AW-1:0]     g_word;
    logic [WSEL_BITS-1:0] g_bit;
    logic                 s1_valid, s2_valid;
    logic [SUB_BITS-1:0]  s1_sub;
    logic [TBL_BITS-1:0]  s1_slot;
    logic [BM_AW-1:0]     s1_word;
    logic [WSEL_BITS-1:0] s1_bit;
    logic [ENT_W-1:0]     s2_entry;
    logic                 s2_occ;

    // Global stall: the whole pipe holds while a result waits downstream.
    always_comb begin
        wsel     = wsel_e'(wr_sel);
        adv      = !(out_valid && !out_ready);
        in_ready = adv;
    end

    vox_addr_gen #(
        .CW(CW), .SUB_BITS(SUB_BITS), .TBL_BITS(TBL_BITS), .WSEL_BITS(WSEL_BITS)
    ) u_addr (
        .x_i(in_x), .y_i(in_y), .z_i(in_z),
        .sub_o(g_sub), .slot_o(g_slot), .bm_word_o(g_word), .bm_bit_o(g_bit)
    );

    // S1 and S2 valid flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
            s2_valid <= 1'b0;
        end else if (adv) begin
            s1_valid <= in_valid;
            s2_valid <= s1_valid;
        end
    end

    // S1 address registers.
    always_ff @(posedge clk) begin
        if (adv) begin
            s1_sub  <= g_sub;
            s1_slot <= g_slot;
            s1_word <= g_word;
            s1_bit  <= g_bit;
        end
    end

    vox_hash_tables #(
        .NUM_SUB(NUM_SUB), .SUB_BITS(SUB_BITS), .TBL_BITS(TBL_BITS), .ENT_W(ENT_W)
    ) u_tables (
        .clk(clk), .adv(adv), .rd_sub(s1_sub), .rd_slot(s1_slot),
        .we(wr_en && wsel == WS_TABLE),
        .wr_addr(wr_addr[TADDR_W-1:0]), .wr_data(wr_data[ENT_W-1:0]),
        .entry_o(s2_entry)
    );

    vox_bitmap #(
        .BM_AW(BM_AW), .WSEL_BITS(WSEL_BITS)
    ) u_bitmap (
        .clk(clk), .adv(adv), .rd_word(s1_word), .rd_bit(s1_bit),
        .we(wr_en && wsel == WS_BITMAP),
        .wr_addr(wr_addr[BM_AW-1:0]), .wr_data(wr_data[WORD_W-1:0]),
        .occ_o(s2_occ)
    );

    vox_feature_route #(
        .IDX_W(IDX_W), .DENS_W(DENS_W), .FEAT_W(FEAT_W),
        .CB_DEPTH(CB_DEPTH), .RAW_DEPTH(RAW_DEPTH)
    ) u_route (
        .clk(clk), .rst_n(rst_n), .adv(adv), .valid_i(s2_valid),
        .idx_i(s2_entry[IDX_W-1:0]), .dens_i(s2_entry[ENT_W-1:IDX_W]), .occ_i(s2_occ),
        .we_cb(wr_en && wsel == WS_CODEBOOK), .we_raw(wr_en && wsel == WS_RAW),
        .wa_cb(wr_addr[CB_AW-1:0]), .wa_raw(wr_addr[RAW_AW-1:0]),
        .wd(wr_data[FEAT_W-1:0]),
        .valid_o(out_valid), .feat_o(out_feat), .dens_o(out_dens), .raw_o(out_raw)
    );

    AST_ACCEPT_ENTERS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready |=> s1_valid); // R8
    AST_STAGE_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        s2_valid && in_ready |=> out_valid); // R8
    AST_STALL_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid); // R9
endmodule

// File: tb/sim_vox_sparse_lookup.sv
// Bench for vox_sparse_lookup. A behavioural reference (plain arrays and a
// three-slot model pipeline) predicts every output and is compared each cycle.
module sim_vox_sparse_lookup;
    localparam int CLK_PERIOD = 10;
    localparam int NSUB  = 4;
    localparam int TBL   = 64;
    localparam int CB    = 256;
    localparam int RAWD  = 256;
    localparam int WDOG  = 100000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [3:0]  in_x = '0, in_y = '0, in_z = '0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [15:0] out_feat, out_dens;
    logic        out_raw;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = '0;
    logic [7:0]  wr_addr = '0;
    logic [33:0] wr_data = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    vox_sparse_lookup u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_x(in_x), .in_y(in_y), .in_z(in_z), .out_valid(out_valid),
        .out_ready(out_ready), .out_feat(out_feat), .out_dens(out_dens),
        .out_raw(out_raw), .wr_en(wr_en), .wr_sel(wr_sel), .wr_addr(wr_addr),
        .wr_data(wr_data)
    );

    typedef struct {
        logic [15:0] feat;
        logic [15:0] dens;
        logic        raw;
        string       tag;
    } exp_t;

    // Reference memories, filled by the write task.
    logic [33:0] m_tab [NSUB*TBL];
    logic [15:0] m_cb  [CB];
    logic [15:0] m_raw [RAWD];
    logic [31:0] m_bm  [128];
    bit          used  [NSUB*TBL];

    exp_t mp [3];
    bit   mv [3];

    int  compared = 0, mismatched = 0, cyc = 0, ready_mode = 0;
    bit  started = 0, done = 0;
    int  occ_x [$], occ_y [$], occ_z [$];

    function automatic int slot_of(int x, int y, int z);
        longint unsigned h;
        h = longint'(x) ^ (longint'(y) * 64'd2654435761) ^ (longint'(z) * 64'd805459861);
        return int'(h % 64);
    endfunction

    function automatic bit occ_of(int x, int y, int z);
        int lin = x * 256 + y * 16 + z;
        return m_bm[lin / 32][lin % 32];
    endfunction

    // Expected result of one lookup (R1 R2 R3 R4 R5 R6 R7).
    function automatic exp_t predict(int x, int y, int z);
        exp_t e;
        logic [33:0] ent = m_tab[(x / 4) * TBL + slot_of(x, y, z)];
        int idx = int'(ent[17:0]);
        logic [15:0] val;
        e.raw = idx >= CB;
        val = e.raw ? m_raw[(idx - CB) % RAWD] : m_cb[idx];
        if (occ_of(x, y, z)) begin
            e.feat = val;
            e.dens = ent[33:18];
            e.tag  = e.raw ? "R5 R1 R2 R3 R7 R11" : "R4 R1 R2 R3 R7 R11";
        end else begin
            e.feat = '0;
            e.dens = '0;
            e.tag  = "R6 masked";
        end
        return e;
    endfunction

    task automatic chk(bit ok, string req, string what, longint act, longint exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s %s actual=%0h expected=%0h t=%0t", req, what, act, exp, $time);
        end
    endtask

    // Reference pipeline: three slots advancing unless the output is held (R8 R9).
    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            mv[0] = 0; mv[1] = 0; mv[2] = 0;
        end else if (!(mv[2] && !out_ready)) begin
            mv[2] = mv[1]; mp[2] = mp[1];
            mv[1] = mv[0]; mp[1] = mp[0];
            mv[0] = in_valid;
            if (in_valid) mp[0] = predict(int'(in_x), int'(in_y), int'(in_z));
        end
    end

    // Downstream readiness patterns used to exercise backpressure (R9).
    always @(negedge clk) begin
        case (ready_mode)
            1:       out_ready <= (cyc % 3) != 0;
            2:       out_ready <= (cyc % 8) >= 3;
            default: out_ready <= 1'b1;
        endcase
    end

    // Per-cycle comparison, away from the active edge.
    always @(negedge clk) begin
        #2;
        if (started && rst_n) begin
            chk(out_valid == mv[2], "R8 R9", "out_valid", longint'(out_valid), longint'(mv[2]));
            chk(in_ready == !(mv[2] && !out_ready), "R9", "in_ready",
                longint'(in_ready), longint'(!(mv[2] && !out_ready)));
            if (out_valid && mv[2]) begin
                chk(out_feat == mp[2].feat, mp[2].tag, "out_feat", longint'(out_feat), longint'(mp[2].feat));
                chk(out_dens == mp[2].dens, mp[2].tag, "out_dens", longint'(out_dens), longint'(mp[2].dens));
                chk(out_raw == mp[2].raw, mp[2].raw ? "R5" : "R4", "out_raw",
                    longint'(out_raw), longint'(mp[2].raw));
            end
        end
    end

    // Preload write through the port (R11), mirrored into the reference arrays.
    task automatic wr(int sel, int addr, logic [33:0] data);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = 2'(sel); wr_addr = 8'(addr); wr_data = data;
        case (sel)
            0: m_tab[addr] = data;
            1: m_cb[addr]  = data[15:0];
            2: m_raw[addr] = data[15:0];
            default: m_bm[addr] = data[31:0];
        endcase
        @(posedge clk);
    endtask

    task automatic lookup(int x, int y, int z);
        @(negedge clk);
        in_valid = 1'b1; in_x = 4'(x); in_y = 4'(y); in_z = 4'(z);
        #1;
        while (!in_ready) begin
            @(negedge clk);
            #1;
        end
        @(posedge clk);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            wr_en = 1'b0;
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    endtask

    always @(posedge clk) begin
        if (!done && cyc > WDOG) begin
            done = 1;
            chk(0, "R8", "watchdog", longint'(cyc), longint'(WDOG));
            summary();
            $finish;
        end
    end

    initial begin
        int k = 0;
        int seed = 7;
        for (int i = 0; i < 128; i++) m_bm[i] = '0;
        for (int i = 0; i < NSUB*TBL; i++) used[i] = 0;

        // Reset state (R10).
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #2;
        chk(out_valid == 1'b0, "R10", "out_valid after reset", longint'(out_valid), 0);
        chk(in_ready == 1'b1, "R10", "in_ready after reset", longint'(in_ready), 1);
        started = 1;

        // Feature memories and default table contents (R11 R3).
        for (int i = 0; i < CB; i++)   wr(1, i, 34'(16'hC000 ^ 16'(i * 37)));
        for (int i = 0; i < RAWD; i++) wr(2, i, 34'(8'(i * 11 + 3)));
        for (int e = 0; e < NSUB*TBL; e++) wr(0, e, {16'(16'h4000 + e), 18'(CB + (e % RAWD))});

        // Occupied vertices: one per table entry, boundary indices first (R4 R5).
        for (int n = 0; n < 60; n++) begin
            int x = (n * 5 + 1) % 16, y = (n * 7 + 3) % 16, z = (n * 3 + n / 4) % 16;
            int ea = (x / 4) * TBL + slot_of(x, y, z);
            int idx;
            int lin = x * 256 + y * 16 + z;
            if (used[ea] || occ_of(x, y, z)) continue;
            used[ea] = 1;
            if (k == 0)      idx = CB - 1;
            else if (k == 1) idx = CB;
            else if (k == 2) idx = 0;
            else if (k % 2)  idx = CB + ((k * 13) % RAWD);
            else             idx = (k * 17) % CB;
            wr(0, ea, {16'(16'h2000 + k), 18'(idx)});
            m_bm[lin / 32][lin % 32] = 1'b1;
            occ_x.push_back(x); occ_y.push_back(y); occ_z.push_back(z);
            k++;
        end
        // Occupancy bitmap words (R6 R11).
        for (int w = 0; w < 128; w++) wr(3, w, 34'(m_bm[w]));
        idle(2);

        // Phase A: occupied vertices back to back (R4 R5 R7 R8).
        foreach (occ_x[i]) lookup(occ_x[i], occ_y[i], occ_z[i]);
        idle(4);

        // Phase B: empty vertices that collide with occupied entries (R6).
        begin
            int found = 0;
            for (int v = 0; v < 4096 && found < 10; v++) begin
                int x = v / 256, y = (v / 16) % 16, z = v % 16;
                if (!occ_of(x, y, z) && used[(x / 4) * TBL + slot_of(x, y, z)]) begin
                    lookup(x, y, z);
                    found++;
                end
            end
        end
        // Pseudo-random vertices across all slabs (R1 R2 R6).
        for (int i = 0; i < 120; i++) begin
            seed = seed * 1103515245 + 12345;
            lookup((seed >>> 8) & 15, (seed >>> 12) & 15, (seed >>> 16) & 15);
        end
        idle(4);

        // Phase C: periodic backpressure (R9).
        ready_mode = 1;
        foreach (occ_x[i]) lookup(occ_x[i], occ_y[i], occ_z[i]);
        // Phase D: long stalls mixed with input gaps (R8 R9).
        ready_mode = 2;
        for (int i = 0; i < 80; i++) begin
            seed = seed * 1103515245 + 12345;
            if (i % 5 == 0) idle(1);
            if (i % 2) lookup(occ_x[i % occ_x.size()], occ_y[i % occ_y.size()], occ_z[i % occ_z.size()]);
            else       lookup((seed >>> 8) & 15, (seed >>> 12) & 15, (seed >>> 16) & 15);
        end
        ready_mode = 0;
        idle(12);

        done = 1;
        summary();
        $finish;
    end
endmodule